// File: doc/BRIEF.md
# Register Stack Push/Pop Unit

This block executes one-byte stack instructions against a private file of eight 32-bit registers. An opcode byte arrives on a valid/ready handshake. A push copies one register onto a downward-growing stack in data memory. A pop loads a memory word back into a register. Register index 4 serves as the stack pointer and is also an ordinary member of the file.

The unit drives a single synchronous memory port. The port carries a byte address, a 32-bit write word, a write strobe and a read strobe. Read data returns one cycle after the read strobe. The unit is multi-cycle and holds `op_ready` low until the current instruction has fully retired.

Any other opcode byte is accepted in one cycle and discarded. The register contents are visible only through the memory traffic the unit produces, so pushes act as the read-out path and pops act as the load path.

Top module: `stack_unit`

## Requirements
- R1: While `rst_n` is low, and for two clock edges after it rises, `op_ready` is 0. Reset clears every register to zero, except the stack pointer (index 4), which takes the parameter `SP_INIT` (default 0x00000100).
- R2: Opcode bytes 0x50 through 0x57 push a register and 0x58 through 0x5F pop into a register. Opcode bits 2:0 select the register.
- R3: A push accepted at edge k drives exactly one write in the following cycle. The write goes to address SP−4 and carries the selected register. The stack pointer becomes SP−4, and `op_ready` is low for exactly that one cycle.
- R4: A pop accepted at edge k drives `mem_re` with address SP in the following cycle. In the cycle after that, the returned word is written into the selected register. The stack pointer becomes SP+4, and `op_ready` is low for exactly those two cycles.
- R5: The data word is little-endian. Bits 7:0 of `mem_wdata` and `mem_rdata` belong to the byte at `mem_addr`, and bits 31:24 belong to the byte at `mem_addr`+3.
- R6: Pushing the stack pointer itself stores its value from before the decrement.
- R7: Popping into the stack pointer leaves it equal to the loaded word, because the register write comes after the increment.
- R8: Stack-pointer arithmetic wraps modulo 2^32. For example, 0 − 4 gives 0xFFFFFFFC, and 0xFFFFFFFC + 4 gives 0.
- R9: Any opcode outside 0x50–0x5F is accepted with `op_ready` staying high. It causes no memory access and changes no register.
- R10: `mem_we` and `mem_re` are never high together, and neither is high in a cycle where `op_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Opcode byte offered |
| op_byte | input | 8 | Instruction opcode |
| op_ready | output | 1 | Unit idle and able to take an opcode |
| mem_addr | output | 32 | Byte address of the accessed word |
| mem_we | output | 1 | Write strobe for the 32-bit word |
| mem_re | output | 1 | Read strobe; data returns next cycle |
| mem_wdata | output | 32 | Little-endian write word |
| mem_rdata | input | 32 | Little-endian read word, one cycle after `mem_re` |

## Verification
The assertions assume the memory returns read data exactly one cycle after `mem_re` and never stalls. They also assume `op_byte` is meaningful only when sampled with `op_valid` and `op_ready` both high. The bench's memory model registers every read on the edge that follows the strobe. The bench raises `op_valid` only after it has seen `op_ready` high, and it drops `op_valid` one edge later. So every offered opcode is taken exactly once, and nothing is offered while an instruction is in flight.

// File: rtl/stack_pkg.sv
package stack_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PUSH   = 2'd1,
    ST_POP_RD = 2'd2,
    ST_POP_WB = 2'd3
  } stk_state_e;
endpackage

// File: rtl/stack_decode.sv
module stack_decode #(
  parameter int          OPW       = 8,
  parameter int          IW        = 3,
  parameter logic [7:0]  PUSH_BASE = 8'h50,
  parameter logic [7:0]  POP_BASE  = 8'h58
) (
  input  logic [OPW-1:0] opcode,
  output logic           is_push,
  output logic           is_pop,
  output logic [IW-1:0]  reg_idx
);
  // Group match on the bits above the register field
  assign is_push = (opcode[OPW-1:IW] == PUSH_BASE[OPW-1:IW]);
  assign is_pop  = (opcode[OPW-1:IW] == POP_BASE[OPW-1:IW]);
  assign reg_idx = opcode[IW-1:0];
endmodule

// File: rtl/stack_regfile.sv
module stack_regfile #(
  parameter int              DW      = 32,
  parameter int              NREG    = 8,
  parameter int              IW      = $clog2(NREG),
  parameter int              SP_IDX  = 4,
  parameter logic [DW-1:0]   SP_INIT = 32'h0000_0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] sp_q,
  input  logic          sp_we,
  input  logic [DW-1:0] sp_d,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_d
);
  logic [NREG-1:0][DW-1:0] q;
  logic [NREG-1:0][DW-1:0] nxt;
  logic [NREG-1:0]         hit;
  logic [NREG-1:0]         en;

  // Per-entry write steering; general write port wins over SP update
  for (genvar g = 0; g < NREG; g++) begin : g_ent
    assign hit[g] = wr_en && (wr_idx == IW'(g));
    if (g == SP_IDX) begin : g_sp
      assign en[g]  = hit[g] | sp_we;
      assign nxt[g] = hit[g] ? wr_d : sp_d;
    end else begin : g_gp
      assign en[g]  = hit[g];
      assign nxt[g] = wr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++)
        q[i] <= (i == SP_IDX) ? SP_INIT : '0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (en[i]) q[i] <= nxt[i];
    end
  end

  assign rd_data = q[rd_idx];
  assign sp_q    = q[SP_IDX];
endmodule

// File: rtl/stack_ctrl.sv
module stack_ctrl
  import stack_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic          is_push,
  input  logic          is_pop,
  input  logic [IW-1:0] dec_idx,
  input  logic [DW-1:0] sp_q,
  input  logic [DW-1:0] rd_data,
  input  logic [DW-1:0] mem_rdata,
  output logic          op_ready,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic [IW-1:0] rd_idx,
  output logic          sp_we,
  output logic [DW-1:0] sp_d,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [DW-1:0] wr_d
);
  localparam logic [DW-1:0] STEP = DW'(DW / 8);

  stk_state_e    st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          idx_en;
  logic          accept;

  assign op_ready = (st_q == ST_IDLE);
  assign accept   = op_valid && op_ready;

  always_comb begin
    st_d      = st_q;
    idx_d     = dec_idx;
    idx_en    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    sp_we     = 1'b0;
    sp_d      = sp_q;
    wr_en     = 1'b0;
    wr_idx    = idx_q;
    wr_d      = mem_rdata;
    rd_idx    = idx_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          idx_en = 1'b1;
          if (is_push)     st_d = ST_PUSH;
          else if (is_pop) st_d = ST_POP_RD;
        end
      end
      ST_PUSH: begin
        // decrement first, store at the new top; operand read is pre-decrement
        sp_d      = sp_q - STEP;
        sp_we     = 1'b1;
        mem_addr  = sp_q - STEP;
        mem_wdata = rd_data;
        mem_we    = 1'b1;
        st_d      = ST_IDLE;
      end
      ST_POP_RD: begin
        mem_addr = sp_q;
        mem_re   = 1'b1;
        sp_d     = sp_q + STEP;
        sp_we    = 1'b1;
        st_d     = ST_POP_WB;
      end
      ST_POP_WB: begin
        wr_en = 1'b1;
        st_d  = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      st_q <= st_d;
      if (idx_en) idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/stack_unit.sv
module stack_unit #(
  parameter int             DW        = 32,
  parameter int             NREG      = 8,
  parameter int             SP_IDX    = 4,
  parameter logic [DW-1:0]  SP_INIT   = 32'h0000_0100,
  parameter logic [7:0]     PUSH_BASE = 8'h50,
  parameter logic [7:0]     POP_BASE  = 8'h58
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [7:0]    op_byte,
  output logic          op_ready,
  output logic [DW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int IW = $clog2(NREG);

  logic [1:0]    rst_sync;
  logic          core_rst_n;
  logic          is_push, is_pop;
  logic [IW-1:0] dec_idx, rd_idx, wr_idx;
  logic [DW-1:0] sp_q, sp_d, rd_data, wr_d;
  logic          sp_we, wr_en, ctrl_ready;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  stack_decode #(
    .OPW(8), .IW(IW), .PUSH_BASE(PUSH_BASE), .POP_BASE(POP_BASE)
  ) u_dec (
    .opcode(op_byte), .is_push(is_push), .is_pop(is_pop), .reg_idx(dec_idx)
  );

  stack_regfile #(
    .DW(DW), .NREG(NREG), .IW(IW), .SP_IDX(SP_IDX), .SP_INIT(SP_INIT)
  ) u_rf (
    .clk(clk), .rst_n(core_rst_n),
    .rd_idx(rd_idx), .rd_data(rd_data), .sp_q(sp_q),
    .sp_we(sp_we), .sp_d(sp_d),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_d(wr_d)
  );

  stack_ctrl #(.DW(DW), .IW(IW)) u_ctrl (
    .clk(clk), .rst_n(core_rst_n),
    .op_valid(op_valid && core_rst_n),
    .is_push(is_push), .is_pop(is_pop), .dec_idx(dec_idx),
    .sp_q(sp_q), .rd_data(rd_data), .mem_rdata(mem_rdata),
    .op_ready(ctrl_ready),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re),
    .rd_idx(rd_idx), .sp_we(sp_we), .sp_d(sp_d),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_d(wr_d)
  );

  assign op_ready = ctrl_ready && core_rst_n;
endmodule

// File: rtl/stack_unit_chk.sv
module stack_unit_chk #(
  parameter int         DW        = 32,
  parameter logic [7:0] PUSH_BASE = 8'h50,
  parameter logic [7:0] POP_BASE  = 8'h58
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [7:0]    op_byte,
  input logic          op_ready,
  input logic [DW-1:0] mem_addr,
  input logic          mem_we,
  input logic          mem_re,
  input logic [DW-1:0] mem_wdata,
  input logic [DW-1:0] mem_rdata
);
  logic take, take_push, take_pop;
  assign take      = op_valid && op_ready;
  assign take_push = take && (op_byte[7:3] == PUSH_BASE[7:3]);
  assign take_pop  = take && (op_byte[7:3] == POP_BASE[7:3]);

  // R10
  excl_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> (!mem_we && !mem_re));

  // R3
  push_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_push |=> (mem_we && !op_ready));

  // R3
  push_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> op_ready);

  // R4
  pop_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_pop |=> (mem_re && !op_ready));

  // R4
  pop_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (!op_ready && !mem_we && !mem_re));

  // R9
  ignore_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !take_push && !take_pop) |=> (op_ready && !mem_we && !mem_re));
endmodule

bind stack_unit stack_unit_chk #(
  .DW(DW), .PUSH_BASE(PUSH_BASE), .POP_BASE(POP_BASE)
) u_chk (.*);

// File: tb/stack_unit_bench.sv
module stack_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [7:0]  op_byte;
  logic        op_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we, mem_re;

  always #5 clk = ~clk;

  stack_unit u_stack_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
    .op_ready(op_ready), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // 256-byte little-endian memory, address taken modulo 256
  logic [7:0] mem [256];
  always @(posedge clk) begin
    if (mem_we)
      for (int k = 0; k < 4; k++) mem[8'(mem_addr[7:0] + 8'(k))] <= mem_wdata[k*8 +: 8];
    if (mem_re)
      mem_rdata <= {mem[8'(mem_addr[7:0] + 8'd3)], mem[8'(mem_addr[7:0] + 8'd2)],
                    mem[8'(mem_addr[7:0] + 8'd1)], mem[mem_addr[7:0]]};
  end

  int          n_chk = 0, n_bad = 0;
  int          wr_cnt = 0, rd_cnt = 0, busy;
  logic [31:0] w_addr, w_data, r_addr, sp_m;

  always @(negedge clk) begin
    if (mem_we) begin wr_cnt++; w_addr = mem_addr; w_data = mem_wdata; end
    if (mem_re) begin rd_cnt++; r_addr = mem_addr; end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  task automatic issue(logic [7:0] op);
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    op_valid = 1'b1; op_byte = op;
    @(negedge clk);
    op_valid = 1'b0;
    busy = 0;
    while (!op_ready) begin busy++; @(negedge clk); end
  endtask

  task automatic put_word(logic [31:0] a, logic [31:0] v);
    for (int k = 0; k < 4; k++) mem[8'(a[7:0] + 8'(k))] = v[k*8 +: 8];
  endtask

  task automatic pop_into(int idx, logic [31:0] v);
    int rc = rd_cnt;
    put_word(sp_m, v);
    issue(8'h58 | 8'(idx));
    check("R4 pop busy cycles", 32'(busy), 32'd2);
    check("R4 pop read addr", r_addr, sp_m);
    check("R10 one read per pop", 32'(rd_cnt - rc), 32'd1);
    sp_m = sp_m + 32'd4;
    if (idx == 4) sp_m = v;
  endtask

  task automatic push_check(int idx, logic [31:0] exp, string req);
    int wc = wr_cnt;
    issue(8'h50 | 8'(idx));
    sp_m = sp_m - 32'd4;
    check({req, " push data"}, w_data, exp);
    check({req, " push addr"}, w_addr, sp_m);
    check("R3 push busy cycles", 32'(busy), 32'd1);
    check("R10 one write per push", 32'(wc == wr_cnt - 1), 32'd1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; op_valid = 1'b0; op_byte = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 ready low in reset", 32'(op_ready), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready low during release", 32'(op_ready), 32'd0);
    repeat (2) @(negedge clk);
    check("R1 ready after release", 32'(op_ready), 32'd1);
    sp_m = 32'h100;
    push_check(4, 32'h100, "R1 R6 reset SP");
    push_check(0, 32'h0, "R1 reset EAX");
    push_check(7, 32'h0, "R1 reset EDI");
  endtask

  task automatic t_example();
    pop_into(3, 32'h0000_000a);
    pop_into(4, 32'h64);
    check("R7 pop into SP", sp_m, 32'h64);
    push_check(3, 32'h0a, "R3 example");
    check("R3 example addr", w_addr, 32'h60);
    check("R5 byte0", 32'(mem[8'h60]), 32'h0a);
    check("R5 byte3", 32'(mem[8'h63]), 32'h00);
    pop_into(3, 32'h0000_000a);
    push_check(4, 32'h64, "R4 R6 SP restored");
    pop_into(1, 32'h1122_3344);
    push_check(1, 32'h1122_3344, "R5");
    check("R5 low byte at addr", 32'(mem[w_addr[7:0]]), 32'h44);
    check("R5 high byte at addr+3", 32'(mem[8'(w_addr[7:0] + 8'd3)]), 32'h11);
  endtask

  task automatic t_decode();
    for (int i = 0; i < 8; i++)
      if (i != 4) pop_into(i, 32'hA5A5_0000 | 32'(i * 16 + i));
    pop_into(4, 32'h80);
    for (int i = 0; i < 8; i++)
      push_check(i, (i == 4) ? sp_m : (32'hA5A5_0000 | 32'(i * 16 + i)), "R2 R6 index");
  endtask

  task automatic t_ignore();
    logic [7:0] ops [4] = '{8'h90, 8'h4F, 8'h60, 8'hFF};
    foreach (ops[j]) begin
      int wc = wr_cnt, rc = rd_cnt;
      issue(ops[j]);
      check("R9 ignored busy", 32'(busy), 32'd0);
      check("R9 no memory access", 32'(wr_cnt - wc + rd_cnt - rc), 32'd0);
    end
    push_check(4, sp_m, "R9 SP untouched");
  endtask

  task automatic t_wrap();
    pop_into(2, 32'hDEAD_BEEF);
    pop_into(4, 32'h0);
    push_check(2, 32'hDEAD_BEEF, "R8 wrap down");
    check("R8 wrapped addr", w_addr, 32'hFFFF_FFFC);
    pop_into(5, 32'hDEAD_BEEF);
    check("R8 wrapped read addr", r_addr, 32'hFFFF_FFFC);
    push_check(4, 32'h0, "R8 wrap up");
    pop_into(4, 32'h1234_0040);
    push_check(4, 32'h1234_0040, "R7 R6 SP load");
    check("R7 addr", w_addr, 32'h1234_003C);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    t_reset();
    t_example();
    t_decode();
    t_ignore();
    t_wrap();
    summary();
  end
endmodule